// File: doc/BRIEF.md
# Dual-Clock FIFO with Rewind

This block is a first-in first-out buffer whose write side and read side each run on their own clock. Words enter on a write clock when the write enable is high and leave on a read clock when the read enable is high. The read data is held in an output register. A separate active-low output enable gates the output bus to zero and drives a qualifier that marks when the bus is live. Five status flags report the fill level. Empty and almost-empty are computed in the read domain. Full, half-full and almost-full are computed in the write domain. Each domain sees the other's pointer through a Gray-coded two-flop synchronizer.

A rewind input returns reading to the first word stored after the last reset, so a stored frame can be replayed without rewriting it. The rewind style is a strap captured while master reset is high. With the strap low (zero-latency style), the first stored word is loaded into the output register on the rewind edge itself, and the following reads return the second word, the third, and so on. With the strap high (plain style), the rewind only moves the read position, and the next read returns the first word. Master reset clears both pointers and captures the strap. Partial reset clears both pointers and keeps the captured strap. A rewind is only meaningful after at least two words have been written and read since reset, and with no more than D-2 words written since reset, where D is the depth.

Top module: `rtx_fifo`

## Requirements
- R1: Words are read out in the order they were written, each read loading the oldest unread word into the output register on the read clock edge that performs it.
- R2: Once the pointers have settled, `empty` is high exactly when the stored count is 0, and `aempty` is high exactly when the count is at most AE_OFS.
- R3: Once the pointers have settled, `full` is high exactly when the count equals D = 2**AW, `afull` exactly when the count is at least D-AF_OFS, and `half` exactly when the count is greater than D/2.
- R4: A write while `full` is high stores nothing. A read while `empty` is high leaves the output register and the read position unchanged.
- R5: In zero-latency style (`rt_mode` low during master reset), the rewind edge puts the first word stored since reset on the output, and the next reads return the second and third words.
- R6: In plain style (`rt_mode` high during master reset), the rewind edge leaves the output unchanged, and the next read returns the first word stored since reset.
- R7: In zero-latency style, if the FIFO is empty when the rewind is taken, `empty` falls on that same read clock edge.
- R8: While `oe_n` is high, `dout` is all zeros and `dout_en` is low. While `oe_n` is low, `dout` carries the output register and `dout_en` is high.
- R9: Master reset sets `empty` and `aempty` high, sets `full`, `half` and `afull` low, clears the output register and captures `rt_mode`.
- R10: Partial reset restores the same flag and output state as master reset but keeps the rewind style captured at the last master reset, whatever `rt_mode` holds at the time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous active-high, seen in both domains |
| prst | input | 1 | Partial reset, synchronous active-high, seen in both domains |
| rt_mode | input | 1 | Rewind style strap, sampled during master reset (0 = zero latency) |
| wen | input | 1 | Write enable |
| din | input | DW | Write data |
| ren | input | 1 | Read enable |
| rt | input | 1 | Rewind request, read domain |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DW | Read data, zero while disabled |
| dout_en | output | 1 | High while dout is driven |
| empty | output | 1 | No word stored (read domain) |
| aempty | output | 1 | Count at most AE_OFS (read domain) |
| full | output | 1 | Count equals depth (write domain) |
| half | output | 1 | Count above half the depth (write domain) |
| afull | output | 1 | Count at least depth minus AF_OFS (write domain) |

## Verification
The bench drives short bursts that stop at 1, 3 and 0 stored words. These show whether each almost-empty threshold and the empty boundary is crossed on the right side. A fill to the full depth followed by one extra write shows whether the half, almost-full and full thresholds are placed correctly and whether the extra word leaks into storage. Rewinds are tried in both styles, one of them on an empty FIFO. They separate a rewind that loads the first word at once from one that waits for a read, and they show whether the style survives a partial reset taken with the strap pin changed.

// File: rtl/rtx_fifo_pkg.sv
`timescale 1ns/1ps
package rtx_fifo_pkg;

    localparam int GW = 32;

    typedef enum logic {
        RT_ZERO_LAT = 1'b0,
        RT_PLAIN    = 1'b1
    } rt_style_e;

    typedef struct packed {
        logic empty;
        logic aempty;
    } rd_flags_t;

    typedef struct packed {
        logic full;
        logic half;
        logic afull;
    } wr_flags_t;

    function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW-1:0] from_gray(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/rtx_fifo_sync.sv
`timescale 1ns/1ps
module rtx_fifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rtx_fifo_mem.sv
`timescale 1ns/1ps
module rtx_fifo_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rtx_fifo_wctl.sv
`timescale 1ns/1ps
module rtx_fifo_wctl
    import rtx_fifo_pkg::*;
#(
    parameter int AW     = 4,
    parameter int AF_OFS = 2
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          wen,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output wr_flags_t     flags
);
    localparam int          DEPTH  = 1 << AW;
    localparam logic [AW:0] FULL_V = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_V = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0] AF_V   = (AW+1)'(DEPTH - AF_OFS);

    logic [AW:0]   wbin;
    logic [AW:0]   wbin_nx;
    logic [AW:0]   rbin_s;
    logic [AW:0]   cnt_nx;
    logic [GW-1:0] rconv;
    logic [GW-1:0] wconv;

    assign rconv   = from_gray(GW'(rgray_s));
    assign rbin_s  = rconv[AW:0];
    assign we      = wen && !flags.full;
    assign waddr   = wbin[AW-1:0];
    assign wbin_nx = wbin + (AW+1)'(we);
    assign cnt_nx  = wbin_nx - rbin_s;
    assign wconv   = to_gray(GW'(wbin_nx));

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
            flags <= '0;
        end else begin
            wbin        <= wbin_nx;
            wgray       <= wconv[AW:0];
            flags.full  <= (cnt_nx == FULL_V);
            flags.half  <= (cnt_nx > HALF_V);
            flags.afull <= (cnt_nx >= AF_V);
        end
    end
endmodule

// File: rtl/rtx_fifo_rctl.sv
`timescale 1ns/1ps
module rtx_fifo_rctl
    import rtx_fifo_pkg::*;
#(
    parameter int AW     = 4,
    parameter int AE_OFS = 2
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          mrst,
    input  logic          rt_mode,
    input  logic          ren,
    input  logic          rt,
    input  logic [AW:0]   wgray_s,
    output logic          load,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          zl,
    output rd_flags_t     flags
);
    localparam logic [AW:0] AE_V = (AW+1)'(AE_OFS);

    logic [AW:0]   rbin;
    logic [AW:0]   rbin_nx;
    logic [AW:0]   wbin_s;
    logic [AW:0]   cnt_nx;
    logic [GW-1:0] wconv;
    logic [GW-1:0] rconv;

    assign wconv  = from_gray(GW'(wgray_s));
    assign wbin_s = wconv[AW:0];

    // Rewind takes priority over a read issued on the same edge
    always_comb begin
        load    = 1'b0;
        raddr   = rbin[AW-1:0];
        rbin_nx = rbin;
        if (rt) begin
            if (zl) begin
                load    = 1'b1;
                raddr   = '0;
                rbin_nx = (AW+1)'(1);
            end else begin
                rbin_nx = '0;
            end
        end else if (ren && !flags.empty) begin
            load    = 1'b1;
            rbin_nx = rbin + (AW+1)'(1);
        end
    end

    assign cnt_nx = wbin_s - rbin_nx;
    assign rconv  = to_gray(GW'(rbin_nx));

    always_ff @(posedge rclk) begin
        if (mrst) begin
            zl <= (rt_mode == RT_ZERO_LAT);
        end
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin         <= '0;
            rgray        <= '0;
            flags.empty  <= 1'b1;
            flags.aempty <= 1'b1;
        end else begin
            rbin         <= rbin_nx;
            rgray        <= rconv[AW:0];
            flags.empty  <= (cnt_nx == '0);
            flags.aempty <= (cnt_nx <= AE_V);
        end
    end
endmodule

// File: rtl/rtx_fifo.sv
`timescale 1ns/1ps
module rtx_fifo
    import rtx_fifo_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int AE_OFS = 2,
    parameter int AF_OFS = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          rt_mode,
    input  logic          wen,
    input  logic [DW-1:0] din,
    input  logic          ren,
    input  logic          rt,
    input  logic          oe_n,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          empty,
    output logic          aempty,
    output logic          full,
    output logic          half,
    output logic          afull
);
    logic          rst_any;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;
    logic [AW:0]   wgray;
    logic [AW:0]   rgray;
    logic [AW:0]   wgray_s;
    logic [AW:0]   rgray_s;
    logic          load;
    logic          zl_q;
    logic [DW-1:0] q_r;
    wr_flags_t     wfl;
    rd_flags_t     rfl;

    assign rst_any = mrst | prst;

    rtx_fifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    rtx_fifo_wctl #(.AW(AW), .AF_OFS(AF_OFS)) u_wctl (
        .wclk    (wclk),
        .rst     (rst_any),
        .wen     (wen),
        .rgray_s (rgray_s),
        .we      (we),
        .waddr   (waddr),
        .wgray   (wgray),
        .flags   (wfl)
    );

    rtx_fifo_rctl #(.AW(AW), .AE_OFS(AE_OFS)) u_rctl (
        .rclk    (rclk),
        .rst     (rst_any),
        .mrst    (mrst),
        .rt_mode (rt_mode),
        .ren     (ren),
        .rt      (rt),
        .wgray_s (wgray_s),
        .load    (load),
        .raddr   (raddr),
        .rgray   (rgray),
        .zl      (zl_q),
        .flags   (rfl)
    );

    rtx_fifo_sync #(.W(AW + 1)) u_w2r (
        .clk (rclk),
        .rst (rst_any),
        .d   (wgray),
        .q   (wgray_s)
    );

    rtx_fifo_sync #(.W(AW + 1)) u_r2w (
        .clk (wclk),
        .rst (rst_any),
        .d   (rgray),
        .q   (rgray_s)
    );

    always_ff @(posedge rclk) begin
        if (rst_any) begin
            q_r <= '0;
        end else if (load) begin
            q_r <= rdata;
        end
    end

    assign dout    = oe_n ? '0 : q_r;
    assign dout_en = !oe_n;
    assign empty   = rfl.empty;
    assign aempty  = rfl.aempty;
    assign full    = wfl.full;
    assign half    = wfl.half;
    assign afull   = wfl.afull;
endmodule

// File: rtl/rtx_fifo_chk.sv
`timescale 1ns/1ps
module rtx_fifo_chk #(
    parameter int DW = 8
) (
    input logic          wclk,
    input logic          rclk,
    input logic          mrst,
    input logic          prst,
    input logic          ren,
    input logic          rt,
    input logic          oe_n,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic          empty,
    input logic          aempty,
    input logic          full,
    input logic          half,
    input logic          afull,
    input logic          zl_q
);
    // R3
    full_thresholds_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
        full |-> (afull && half));

    // R2
    empty_aempty_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        empty |-> aempty);

    // R8
    oe_gate_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        oe_n |-> (dout == '0 && !dout_en));

    // R4
    empty_read_hold_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        (empty && ren && !rt && !oe_n) |=> (oe_n || $stable(dout)));

    // R7
    zl_rewind_fill_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        (rt && zl_q) |=> !empty);

    // R9
    mrst_empty_chk: assert property (@(posedge rclk) disable iff (prst)
        mrst |=> (empty && aempty));
endmodule

bind rtx_fifo rtx_fifo_chk #(.DW(DW)) u_chk (
    .wclk    (wclk),
    .rclk    (rclk),
    .mrst    (mrst),
    .prst    (prst),
    .ren     (ren),
    .rt      (rt),
    .oe_n    (oe_n),
    .dout    (dout),
    .dout_en (dout_en),
    .empty   (empty),
    .aempty  (aempty),
    .full    (full),
    .half    (half),
    .afull   (afull),
    .zl_q    (zl_q)
);

// File: tb/rtx_fifo_tb.sv
`timescale 1ns/1ps
module rtx_fifo_tb;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int D  = 1 << AW;
    localparam int AE = 2;
    localparam int AF = 2;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          mrst = 1'b1;
    logic          prst = 1'b0;
    logic          rt_mode = 1'b0;
    logic          wen = 1'b0;
    logic [DW-1:0] din = '0;
    logic          ren = 1'b0;
    logic          rt = 1'b0;
    logic          oe_n = 1'b1;
    logic [DW-1:0] dout;
    logic          dout_en;
    logic          empty, aempty, full, half, afull;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mdl [$];
    int            rcnt = 0;
    logic [DW-1:0] exp_q = '0;
    bit            zl = 1'b1;
    bit            mon_on = 1'b0;
    bit            done = 1'b0;

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    rtx_fifo #(.DW(DW), .AW(AW), .AE_OFS(AE), .AF_OFS(AF)) u_dut (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .rt_mode(rt_mode),
        .wen(wen), .din(din), .ren(ren), .rt(rt), .oe_n(oe_n),
        .dout(dout), .dout_en(dout_en), .empty(empty), .aempty(aempty),
        .full(full), .half(half), .afull(afull)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Output compared against the model on every read clock
    always @(negedge rclk) begin
        if (mon_on) begin
            chk(dout === (oe_n ? '0 : exp_q), "R1/R8 dout per cycle", dout, oe_n ? 0 : exp_q);
            chk(dout_en === !oe_n, "R8 dout_en per cycle", dout_en, !oe_n);
        end
    end

    task automatic settle();
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        @(negedge rclk);
    endtask

    task automatic flags(input string tag);
        int c;
        c = mdl.size() - rcnt;
        chk(empty  === (c == 0),      {tag, " R2 empty"},  empty,  c == 0);
        chk(aempty === (c <= AE),     {tag, " R2 aempty"}, aempty, c <= AE);
        chk(full   === (c == D),      {tag, " R3 full"},   full,   c == D);
        chk(half   === (c > D / 2),   {tag, " R3 half"},   half,   c > D / 2);
        chk(afull  === (c >= D - AF), {tag, " R3 afull"},  afull,  c >= D - AF);
    endtask

    task automatic do_rst(input bit master, input bit mode);
        mon_on = 1'b0;
        rt_mode = mode;
        @(negedge wclk);
        if (master) mrst = 1'b1; else prst = 1'b1;
        repeat (3) @(posedge rclk);
        repeat (3) @(posedge wclk);
        @(negedge wclk);
        mrst = 1'b0;
        prst = 1'b0;
        mdl.delete();
        rcnt = 0;
        exp_q = '0;
        if (master) zl = !mode;
        settle();
        mon_on = 1'b1;
    endtask

    task automatic wr(input logic [DW-1:0] v);
        @(negedge wclk);
        din = v;
        wen = 1'b1;
        @(posedge wclk);
        #1;
        wen = 1'b0;
        if (mdl.size() - rcnt < D) mdl.push_back(v);
    endtask

    task automatic rd_exp(input logic [DW-1:0] v, input string tag);
        @(negedge rclk);
        ren = 1'b1;
        @(posedge rclk);
        #1;
        ren = 1'b0;
        if (rcnt < mdl.size()) begin
            exp_q = mdl[rcnt];
            rcnt++;
        end
        @(negedge rclk);
        chk(dout === v, tag, dout, v);
    endtask

    task automatic rewind();
        @(negedge rclk);
        rt = 1'b1;
        @(posedge rclk);
        #1;
        rt = 1'b0;
        if (zl) begin
            exp_q = mdl[0];
            rcnt = 1;
        end else begin
            rcnt = 0;
        end
    endtask

    task automatic set_oe(input logic v);
        @(posedge rclk);
        #2;
        oe_n = v;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: master reset with zero-latency strap
        do_rst(1'b1, 1'b0);
        chk(empty === 1'b1,  "R9 empty after reset",  empty, 1);
        chk(aempty === 1'b1, "R9 aempty after reset", aempty, 1);
        chk(full === 1'b0,   "R9 full after reset",   full, 0);
        chk(half === 1'b0,   "R9 half after reset",   half, 0);
        chk(afull === 1'b0,  "R9 afull after reset",  afull, 0);
        chk(dout === '0,     "R9 dout after reset",   dout, 0);
        set_oe(1'b0);

        // R1, R2: small bursts across the almost-empty threshold
        wr(8'hA1); wr(8'hA2); wr(8'hA3);
        settle(); flags("three");
        rd_exp(8'hA1, "R1 first read");
        rd_exp(8'hA2, "R1 second read");
        settle(); flags("one");
        rd_exp(8'hA3, "R1 third read");
        settle(); flags("drained");

        // R4: read on empty holds output
        rd_exp(8'hA3, "R4 read while empty holds dout");
        settle(); flags("R4 after empty read");

        // R5, R7: zero-latency rewind taken while empty
        rewind();
        chk(empty === 1'b0, "R7 empty falls on rewind edge", empty, 0);
        chk(dout === 8'hA1, "R5 first word on rewind edge", dout, 8'hA1);
        rd_exp(8'hA2, "R5 second word after rewind");
        rd_exp(8'hA3, "R5 third word after rewind");
        settle(); flags("R5 after replay");

        // R8: output enable gating
        set_oe(1'b1);
        @(negedge rclk);
        chk(dout === '0,     "R8 dout zero when disabled", dout, 0);
        chk(dout_en === 1'b0, "R8 dout_en low when disabled", dout_en, 0);
        set_oe(1'b0);
        @(negedge rclk);
        chk(dout === 8'hA3,  "R8 dout restored when enabled", dout, 8'hA3);

        // R10: partial reset with strap changed keeps zero-latency style
        do_rst(1'b0, 1'b1);
        flags("R10 after partial reset");
        chk(dout === '0, "R10 dout cleared", dout, 0);
        wr(8'hB0); wr(8'hB1); wr(8'hB2); wr(8'hB3);
        settle();
        rd_exp(8'hB0, "R10 read");
        rd_exp(8'hB1, "R10 read");
        rewind();
        chk(dout === 8'hB0, "R10 style kept: first word on rewind edge", dout, 8'hB0);
        rd_exp(8'hB1, "R10 read after rewind");
        settle(); flags("R10 end");

        // R3, R4: fill to depth, then one write too many
        do_rst(1'b0, 1'b0);
        for (int i = 0; i < D; i++) begin
            wr(8'hC0 + 8'(i));
            settle();
            flags("R3 fill");
        end
        wr(8'hEE);
        settle(); flags("R4 write while full");
        for (int i = 0; i < D; i++) begin
            rd_exp(8'hC0 + 8'(i), "R4 contents after overfill");
        end
        settle(); flags("R4 drained");

        // R6: plain-style rewind
        do_rst(1'b1, 1'b1);
        wr(8'hD1); wr(8'hD2); wr(8'hD3);
        settle();
        rd_exp(8'hD1, "R6 read");
        rd_exp(8'hD2, "R6 read");
        rewind();
        chk(dout === 8'hD2, "R6 output unchanged on rewind edge", dout, 8'hD2);
        rd_exp(8'hD1, "R6 first word after rewind");
        rd_exp(8'hD2, "R6 second word after rewind");
        rd_exp(8'hD3, "R6 third word after rewind");
        settle(); flags("R6 end");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule